// File: doc/BRIEF.md
# Dual-Address DMA Channel with Size Packing

This block is one DMA channel that moves data memory-to-memory in dual-address fashion. Every datum is fetched from a source address in one bus access and stored to a destination address in a separate access. The source and destination access sizes are programmed independently: byte, word, longword or a 16-byte line. A 16-byte packing buffer sits between the two sides. It gathers narrow reads until one destination write of the programmed size can be formed, and it also splits a wide read into several narrow writes. A line access on either side is issued as an indivisible four-beat longword burst with the bus lock held on every beat.

Software controls the channel through a small register port. The registers are a control word (enable, soft reset, addressing modes, sizes and an access-type qualifier), a source address, a destination address, a byte count and a status word that holds a done flag. Once enabled, the channel generates its own requests and runs until the byte count reaches zero. It then raises the done flag and drops the enable. A pending done flag keeps the channel from starting any further transfer until software clears it.

Register map (word index on `reg_addr`): 0 control, 1 source address, 2 destination address, 3 byte count, 4 status. Control bits: [0] enable, [1] soft reset (write-only, reads 0), [3:2] destination mode, [4] source increment, [6:5] destination size, [8:7] source size, [11:9] destination access type. Status bit [0] is the done flag; writing 1 to it clears it. The byte count must be a multiple of the larger of the two access sizes.

Top module: `dpk_dma`

## Requirements
- R1: After `rst_n` is released, every register reads 0, `xfer_done` is 0 and `mem_req` is 0.
- R2: A control write with bit [1] set clears the enable bit, even when bit [0] is set in the same write. From the next cycle it stops any bus access, including one acknowledged in that same cycle, and it empties the packing buffer, so the next run starts with no leftover bytes.
- R3: A bus request begins only while the enable bit is 1 and the done flag is 0. With enable at 0 the channel issues no access.
- R4: Each datum is moved by a read access at the source address (`mem_we`=0) followed by a separate write access at the destination address (`mem_we`=1).
- R5: Size codes for both fields are 00 longword (4 bytes), 01 byte, 10 word and 11 line (16 bytes). `mem_size` carries the source code on reads and the destination code on writes.
- R6: Source increment 1 advances the source address by the source size after each completed read access. With 0 the address stays fixed.
- R7: Destination mode 01 advances the destination address by the destination size after each completed write access. Modes 00, 10 and 11 keep it fixed.
- R8: A write access starts only when the buffer holds at least a destination-size worth of bytes, and a read starts only when it holds less. Byte reads into a line destination give 16 reads and then one 4-beat write. A line read into byte writes gives 4 read beats and then 16 writes.
- R9: Bytes are packed big-endian: the first byte read becomes the most significant byte of the next write. Byte and word data travel right-justified on `mem_rdata`/`mem_wdata`, and a longword beat carries its lowest-addressed byte in bits [31:24].
- R10: A line access runs as four beats at base, base+4, base+8 and base+12. `mem_lock` is 1 on every beat of a line access and 0 on all other accesses.
- R11: `mem_attr` equals the control destination access-type field during write accesses and is 000 during read accesses.
- R12: The byte count drops by the destination size after each completed write access. The write that brings it to zero sets the done flag and clears the enable. Enabling with a count of zero sets the done flag without any bus access.
- R13: While the done flag is 1 no access starts, even with the enable at 1. Writing 1 to status bit [0] clears the flag, and the pending transfer then runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Bus access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write access, 0 for a read |
| mem_addr | output | ADDR_W | Byte address of the current beat |
| mem_size | output | 2 | Size code of the current access |
| mem_wdata | output | 32 | Write data, right-justified for byte and word |
| mem_rdata | input | 32 | Read data, right-justified for byte and word |
| mem_ack | input | 1 | Beat acknowledge |
| mem_lock | output | 1 | Bus lock, held across a line burst |
| mem_attr | output | 3 | Access-type qualifier |
| xfer_done | output | 1 | Done flag |

## Verification
Two events can land in the same cycle: a soft-reset write to the control word, and the acknowledge of a source read that the packer would otherwise absorb. The bench provokes this by running byte reads into a line destination with a zero-wait memory, so an acknowledge arrives every cycle, and then issuing the reset write partway through the fill. The result is judged by three things: the bus going idle and the enable reading 0 on the next cycle, no write ever appearing, and a restarted run whose 16-byte line holds exactly the source bytes from the first address, which shows that neither the discarded beat nor earlier packed bytes survived.

// File: rtl/dpk_pkg.sv
package dpk_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LINE = 2'b11
  } size_e;

  // Control word bits [11:2], MSB first
  typedef struct packed {
    logic [2:0] attr;
    size_e      src_sz;
    size_e      dst_sz;
    logic       src_inc;
    logic [1:0] dst_mode;
  } cfg_t;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_SRC  = 3'd1;
  localparam logic [2:0] RA_DST  = 3'd2;
  localparam logic [2:0] RA_CNT  = 3'd3;
  localparam logic [2:0] RA_STAT = 3'd4;

  localparam logic [1:0] DM_INC = 2'b01;

  // Bytes moved by one whole access of the given size
  function automatic logic [4:0] size_bytes(size_e s);
    case (s)
      SZ_BYTE: return 5'd1;
      SZ_WORD: return 5'd2;
      SZ_LONG: return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

  // Bytes carried by one beat (a line is four longword beats)
  function automatic logic [2:0] beat_bytes(size_e s);
    case (s)
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // Right-justified bus data -> left-justified (MSB lane first)
  function automatic logic [31:0] lane_left(logic [31:0] d, logic [2:0] n);
    return d << (6'd32 - {n, 3'b000});
  endfunction

  // Left-justified buffer head -> right-justified bus data
  function automatic logic [31:0] lane_right(logic [31:0] h, logic [2:0] n);
    return h >> (6'd32 - {n, 3'b000});
  endfunction

endpackage

// File: rtl/dpk_pack_buf.sv
module dpk_pack_buf
  import dpk_pkg::*;
#(
  parameter int BUF_BYTES = 16,
  localparam int BW = 8 * BUF_BYTES,
  localparam int FW = $clog2(BUF_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [2:0]    push_n,
  input  logic [31:0]   push_data,
  input  logic          pop,
  input  logic [2:0]    pop_n,
  output logic [31:0]   head,
  output logic [FW-1:0] fill
);

  logic [BW-1:0] q;
  logic [BW-1:0] ins;

  // New bytes are placed just below the bytes already held
  assign ins  = {lane_left(push_data, push_n), {(BW-32){1'b0}}} >> {fill, 3'b000};
  assign head = q[BW-1 -: 32];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      q    <= '0;
      fill <= '0;
    end else if (push) begin
      q    <= q | ins;
      fill <= fill + FW'(push_n);
    end else if (pop) begin
      q    <= q << {pop_n, 3'b000};
      fill <= fill - FW'(pop_n);
    end
  end

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || clr)
    push |-> (int'(fill) + int'(push_n)) <= BUF_BYTES)
    else $error("packing buffer overflow");

  a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n || clr)
    pop |-> int'(fill) >= int'(pop_n))
    else $error("packing buffer underflow");

  a_r4_rd_wr_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop))
    else $error("read and write beat in one cycle");

endmodule

// File: rtl/dpk_regs.sv
module dpk_regs
  import dpk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rd_adv,
  input  logic              wr_adv,
  input  logic              idle,
  output cfg_t              cfg,
  output logic              en,
  output logic              done,
  output logic              sw_rst,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CNT_W-1:0]  count
);

  logic [CNT_W-1:0]  dbytes_c;
  logic [ADDR_W-1:0] dbytes_a;
  logic [ADDR_W-1:0] sbytes_a;
  logic              last_wr;
  logic              zero_hit;
  logic              ctrl_wr;

  assign dbytes_c = CNT_W'(size_bytes(cfg.dst_sz));
  assign dbytes_a = ADDR_W'(size_bytes(cfg.dst_sz));
  assign sbytes_a = ADDR_W'(size_bytes(cfg.src_sz));
  assign ctrl_wr  = reg_we && (reg_addr == RA_CTRL);
  assign sw_rst   = ctrl_wr && reg_wdata[1];
  assign last_wr  = wr_adv && (count <= dbytes_c);
  assign zero_hit = idle && en && !done && (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '0;
      en       <= 1'b0;
      done     <= 1'b0;
      src_addr <= '0;
      dst_addr <= '0;
      count    <= '0;
    end else begin
      if (wr_adv) begin
        count <= last_wr ? '0 : count - dbytes_c;
        if (cfg.dst_mode == DM_INC) dst_addr <= dst_addr + dbytes_a;
      end
      if (rd_adv && cfg.src_inc) src_addr <= src_addr + sbytes_a;
      if (last_wr || zero_hit) begin
        done <= 1'b1;
        en   <= 1'b0;
      end
      // software writes take precedence over channel updates
      if (reg_we) begin
        case (reg_addr)
          RA_CTRL: begin
            en  <= reg_wdata[0] && !reg_wdata[1];
            cfg <= cfg_t'(reg_wdata[11:2]);
          end
          RA_SRC:  src_addr <= reg_wdata[ADDR_W-1:0];
          RA_DST:  dst_addr <= reg_wdata[ADDR_W-1:0];
          RA_CNT:  count    <= reg_wdata[CNT_W-1:0];
          RA_STAT: if (reg_wdata[0]) done <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {20'b0, cfg, 1'b0, en};
      RA_SRC:  reg_rdata = 32'(src_addr);
      RA_DST:  reg_rdata = 32'(dst_addr);
      RA_CNT:  reg_rdata = 32'(count);
      RA_STAT: reg_rdata = {31'b0, done};
      default: reg_rdata = '0;
    endcase
  end

  a_r12_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) && !$past(reg_we) |-> !en)
    else $error("done raised with enable still set");

  a_r6_src_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    rd_adv && !cfg.src_inc && !reg_we |=> $stable(src_addr))
    else $error("fixed source address moved");

  a_r12_count_nonzero_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_adv |-> count != '0)
    else $error("write completed with zero count");

endmodule

// File: rtl/dpk_bus_seq.sv
module dpk_bus_seq
  import dpk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int FW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              en,
  input  logic              done,
  input  logic              count_nz,
  input  cfg_t              cfg,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [FW-1:0]     fill,
  input  logic [31:0]       head,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              mem_lock,
  output logic [2:0]        mem_attr,
  output logic              push,
  output logic [2:0]        push_n,
  output logic [31:0]       push_data,
  output logic              pop,
  output logic [2:0]        pop_n,
  output logic              rd_adv,
  output logic              wr_adv,
  output logic              idle
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_e;

  st_e               st;
  logic [1:0]        beat;
  size_e             cur_sz;
  logic              is_line;
  logic              hand;
  logic              last_beat;
  logic              go;
  logic [ADDR_W-1:0] base;

  assign cur_sz    = (st == S_WR) ? cfg.dst_sz : cfg.src_sz;
  assign is_line   = (cur_sz == SZ_LINE);
  assign base      = (st == S_WR) ? dst_addr : src_addr;
  assign mem_req   = (st != S_IDLE);
  assign mem_we    = (st == S_WR);
  assign mem_size  = cur_sz;
  assign mem_addr  = base + (is_line ? ADDR_W'({beat, 2'b00}) : '0);
  assign mem_lock  = mem_req && is_line;
  assign mem_attr  = mem_we ? cfg.attr : 3'b000;
  assign mem_wdata = lane_right(head, beat_bytes(cfg.dst_sz));

  assign hand      = mem_req && mem_ack && !sw_rst;
  assign last_beat = !is_line || (beat == 2'd3);
  assign push      = hand && (st == S_RD);
  assign push_n    = beat_bytes(cfg.src_sz);
  assign push_data = mem_rdata;
  assign pop       = hand && (st == S_WR);
  assign pop_n     = beat_bytes(cfg.dst_sz);
  assign rd_adv    = push && last_beat;
  assign wr_adv    = pop && last_beat;
  assign idle      = (st == S_IDLE);
  assign go        = en && !done && count_nz;

  always_ff @(posedge clk) begin
    if (!rst_n || sw_rst) begin
      st   <= S_IDLE;
      beat <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          beat <= '0;
          if (go) st <= (FW'(size_bytes(cfg.dst_sz)) > fill) ? S_RD : S_WR;
        end
        default: begin
          if (hand) begin
            if (last_beat) begin
              st   <= S_IDLE;
              beat <= '0;
            end else begin
              beat <= beat + 2'd1;
            end
          end
        end
      endcase
    end
  end

  a_r2_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> !mem_req)
    else $error("access continued after soft reset");

  a_r3_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(en) && !$past(done))
    else $error("access started while disabled or done");

  a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    mem_lock && !mem_ack |=> mem_lock)
    else $error("lock dropped inside a burst beat");

  a_r10_lock_next_beat: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
    mem_lock && mem_ack && beat != 2'd3 |=> mem_lock && mem_req)
    else $error("lock dropped between burst beats");

  a_r8_write_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> int'(fill) >= int'(pop_n))
    else $error("write issued without enough packed bytes");

endmodule

// File: rtl/dpk_dma.sv
module dpk_dma
  import dpk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BUF_BYTES = 16,
  localparam int FW = $clog2(BUF_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              mem_lock,
  output logic [2:0]        mem_attr,
  output logic              xfer_done
);

  cfg_t              cfg;
  logic              en, done, sw_rst;
  logic [ADDR_W-1:0] src_addr, dst_addr;
  logic [CNT_W-1:0]  count;
  logic              rd_adv, wr_adv, idle;
  logic              push, pop;
  logic [2:0]        push_n, pop_n;
  logic [31:0]       push_data, head;
  logic [FW-1:0]     fill;

  assign xfer_done = done;

  dpk_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_adv(rd_adv),
    .wr_adv(wr_adv), .idle(idle), .cfg(cfg), .en(en), .done(done),
    .sw_rst(sw_rst), .src_addr(src_addr), .dst_addr(dst_addr), .count(count)
  );

  dpk_pack_buf #(.BUF_BYTES(BUF_BYTES)) buf_i (
    .clk(clk), .rst_n(rst_n), .clr(sw_rst), .push(push), .push_n(push_n),
    .push_data(push_data), .pop(pop), .pop_n(pop_n), .head(head), .fill(fill)
  );

  dpk_bus_seq #(.ADDR_W(ADDR_W), .FW(FW)) seq_i (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .en(en), .done(done),
    .count_nz(count != '0), .cfg(cfg), .src_addr(src_addr), .dst_addr(dst_addr),
    .fill(fill), .head(head), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_lock(mem_lock),
    .mem_attr(mem_attr), .push(push), .push_n(push_n), .push_data(push_data),
    .pop(pop), .pop_n(pop_n), .rd_adv(rd_adv), .wr_adv(wr_adv), .idle(idle)
  );

  a_r12_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mem_req |=> !mem_req)
    else $error("access started while done pending");

endmodule

// File: tb/dpk_dma_tb_top.sv
module dpk_dma_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_ack, mem_lock, xfer_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic [2:0]  mem_attr;

  always #2 clk = ~clk;

  dpk_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_lock(mem_lock), .mem_attr(mem_attr), .xfer_done(xfer_done)
  );

  // ---------------- memory model and bus monitor ----------------
  logic [7:0] mem [256];
  logic       ack_ok = 1'b1;
  logic       gap = 1'b0;
  logic       clr_log = 1'b0;
  logic [1:0] exp_rsz = 2'b00, exp_wsz = 2'b00;
  logic [2:0] exp_attr = 3'b000;
  logic [7:0] a;
  int n_rd, n_wr, rd_before_wr, lock_err, attr_err, size_err;
  bit first_wr;
  logic [7:0] wr_log [64];
  logic [7:0] rd_log [64];

  assign a       = mem_addr[7:0];
  assign mem_ack = mem_req && ack_ok;

  always_comb begin
    case (mem_size)
      2'b01:   mem_rdata = {24'b0, mem[a]};
      2'b10:   mem_rdata = {16'b0, mem[a], mem[8'(a + 8'd1)]};
      default: mem_rdata = {mem[a], mem[8'(a + 8'd1)], mem[8'(a + 8'd2)], mem[8'(a + 8'd3)]};
    endcase
  end

  function automatic logic [7:0] seed(int i);
    return 8'(i) ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (clr_log) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
      n_rd = 0; n_wr = 0; rd_before_wr = 0; first_wr = 0;
      lock_err = 0; attr_err = 0; size_err = 0;
      ack_ok <= 1'b1;
    end else begin
      ack_ok <= gap ? ~ack_ok : 1'b1;
      if (mem_req) begin
        if ((mem_size == 2'b11) != mem_lock) lock_err++;
        if (mem_we && mem_attr != exp_attr) attr_err++;
        if (!mem_we && mem_attr != 3'b000) attr_err++;
        if (mem_we && mem_size != exp_wsz) size_err++;
        if (!mem_we && mem_size != exp_rsz) size_err++;
      end
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          case (mem_size)
            2'b01: mem[a] <= mem_wdata[7:0];
            2'b10: begin
              mem[a] <= mem_wdata[15:8];
              mem[8'(a + 8'd1)] <= mem_wdata[7:0];
            end
            default: begin
              mem[a] <= mem_wdata[31:24];
              mem[8'(a + 8'd1)] <= mem_wdata[23:16];
              mem[8'(a + 8'd2)] <= mem_wdata[15:8];
              mem[8'(a + 8'd3)] <= mem_wdata[7:0];
            end
          endcase
          if (!first_wr) begin
            first_wr = 1;
            rd_before_wr = n_rd;
          end
          if (n_wr < 64) wr_log[n_wr] <= a;
          n_wr++;
        end else begin
          if (n_rd < 64) rd_log[n_rd] <= a;
          n_rd++;
        end
      end
    end
  end

  // ---------------- check helpers ----------------
  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = ad; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] ad, output logic [31:0] d);
    reg_addr = ad;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(logic en, logic rs, logic [1:0] dmode, logic sinc,
                                      logic [1:0] dsz, logic [1:0] ssz, logic [2:0] attr);
    return {20'b0, attr, ssz, dsz, sinc, dmode, rs, en};
  endfunction

  task automatic fresh();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      if (xfer_done) break;
      @(negedge clk);
    end
  endtask

  task automatic cmp_bytes(input string req, input int dst, input int src, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (mem[dst + i] !== seed(src + i)) bad++;
    chk(req, "byte mismatches", 32'(bad), 32'd0);
  endtask

  task automatic setup(input int src, input int dst, input int cnt);
    wr(3'd1, 32'(src));
    wr(3'd2, 32'(dst));
    wr(3'd3, 32'(cnt));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    logic [31:0] v;
    chk("R1", "mem_req", 32'(mem_req), 32'd0);
    chk("R1", "xfer_done", 32'(xfer_done), 32'd0);
    rd(3'd0, v); chk("R1", "ctrl", v, 32'd0);
    rd(3'd3, v); chk("R1", "count", v, 32'd0);
    rd(3'd4, v); chk("R1", "status", v, 32'd0);
  endtask

  task automatic t_gate();
    fresh();
    setup(16, 128, 8);
    wr(3'd0, ctl(1'b0, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 3'b001));
    repeat (20) @(negedge clk);
    chk("R3", "accesses while disabled", 32'(n_rd + n_wr), 32'd0);
  endtask

  task automatic t_byte_to_line();
    logic [31:0] v;
    fresh();
    exp_rsz = 2'b01; exp_wsz = 2'b11; exp_attr = 3'b101;
    setup(16, 128, 32);
    wr(3'd0, ctl(1'b1, 1'b0, 2'b01, 1'b1, 2'b11, 2'b01, 3'b101));
    wait_done();
    @(negedge clk);
    chk("R8", "reads", 32'(n_rd), 32'd32);
    chk("R10", "write beats", 32'(n_wr), 32'd8);
    chk("R8", "reads before first write", 32'(rd_before_wr), 32'd16);
    chk("R6", "second read addr", 32'(rd_log[1]), 32'h11);
    chk("R10", "beat 1 addr", 32'(wr_log[1]), 32'h84);
    chk("R10", "beat 3 addr", 32'(wr_log[3]), 32'h8C);
    chk("R7", "second burst addr", 32'(wr_log[4]), 32'h90);
    cmp_bytes("R9", 128, 16, 32);
    chk("R10", "lock errors", 32'(lock_err), 32'd0);
    chk("R11", "attr errors", 32'(attr_err), 32'd0);
    chk("R5", "size errors", 32'(size_err), 32'd0);
    chk("R12", "done", 32'(xfer_done), 32'd1);
    rd(3'd0, v); chk("R12", "enable after done", 32'(v[0]), 32'd0);
    rd(3'd3, v); chk("R12", "count", v, 32'd0);
    rd(3'd1, v); chk("R6", "final src", v, 32'h30);
    rd(3'd2, v); chk("R7", "final dst", v, 32'hA0);
  endtask

  task automatic t_line_to_byte();
    fresh();
    wr(3'd4, 32'd1);
    gap = 1'b1;
    exp_rsz = 2'b11; exp_wsz = 2'b01; exp_attr = 3'b001;
    setup(64, 192, 16);
    wr(3'd0, ctl(1'b1, 1'b0, 2'b01, 1'b1, 2'b01, 2'b11, 3'b001));
    wait_done();
    @(negedge clk);
    gap = 1'b0;
    chk("R8", "read beats", 32'(n_rd), 32'd4);
    chk("R8", "byte writes", 32'(n_wr), 32'd16);
    chk("R8", "beats before first write", 32'(rd_before_wr), 32'd4);
    chk("R10", "third read beat addr", 32'(rd_log[2]), 32'h48);
    chk("R7", "last write addr", 32'(wr_log[15]), 32'hCF);
    cmp_bytes("R9", 192, 64, 16);
    chk("R10", "lock errors", 32'(lock_err), 32'd0);
    chk("R11", "attr errors", 32'(attr_err), 32'd0);
    chk("R5", "size errors", 32'(size_err), 32'd0);
  endtask

  task automatic t_fixed_src();
    logic [31:0] v;
    int bad = 0;
    fresh();
    wr(3'd4, 32'd1);
    exp_rsz = 2'b10; exp_wsz = 2'b00; exp_attr = 3'b010;
    setup(32, 96, 8);
    wr(3'd0, ctl(1'b1, 1'b0, 2'b01, 1'b0, 2'b00, 2'b10, 3'b010));
    wait_done();
    @(negedge clk);
    chk("R4", "word reads", 32'(n_rd), 32'd4);
    chk("R4", "long writes", 32'(n_wr), 32'd2);
    chk("R6", "fourth read addr fixed", 32'(rd_log[3]), 32'h20);
    chk("R7", "second write addr", 32'(wr_log[1]), 32'h64);
    for (int i = 0; i < 8; i++) if (mem[96 + i] !== seed(32 + (i % 2))) bad++;
    chk("R9", "repeated word packing", 32'(bad), 32'd0);
    rd(3'd1, v); chk("R6", "src unchanged", v, 32'h20);
    chk("R5", "size errors", 32'(size_err), 32'd0);
  endtask

  task automatic t_fixed_dst(input logic [1:0] mode, input int dst);
    logic [31:0] v;
    int bad = 0;
    fresh();
    wr(3'd4, 32'd1);
    exp_rsz = 2'b00; exp_wsz = 2'b00; exp_attr = 3'b110;
    setup(0, dst, 12);
    wr(3'd0, ctl(1'b1, 1'b0, mode, 1'b1, 2'b00, 2'b00, 3'b110));
    wait_done();
    @(negedge clk);
    chk("R7", "writes", 32'(n_wr), 32'd3);
    chk("R7", "third write addr fixed", 32'(wr_log[2]), 32'(dst));
    for (int i = 0; i < 4; i++) if (mem[dst + i] !== seed(8 + i)) bad++;
    chk("R7", "last longword kept", 32'(bad), 32'd0);
    rd(3'd2, v); chk("R7", "dst reg unchanged", v, 32'(dst));
  endtask

  task automatic t_zero_count();
    logic [31:0] v;
    fresh();
    wr(3'd4, 32'd1);
    wr(3'd3, 32'd0);
    wr(3'd0, ctl(1'b1, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 3'b001));
    repeat (3) @(negedge clk);
    chk("R12", "done with zero count", 32'(xfer_done), 32'd1);
    chk("R12", "no access for zero count", 32'(n_rd + n_wr), 32'd0);
    rd(3'd0, v); chk("R12", "enable cleared", 32'(v[0]), 32'd0);
  endtask

  task automatic t_done_blocks();
    logic [31:0] v;
    fresh();
    exp_rsz = 2'b00; exp_wsz = 2'b00; exp_attr = 3'b001;
    setup(0, 144, 4);
    wr(3'd0, ctl(1'b1, 1'b0, 2'b01, 1'b1, 2'b00, 2'b00, 3'b001));
    repeat (20) @(negedge clk);
    chk("R13", "accesses while done", 32'(n_rd + n_wr), 32'd0);
    rd(3'd0, v); chk("R13", "enable held", 32'(v[0]), 32'd1);
    wr(3'd4, 32'd1);
    wait_done();
    @(negedge clk);
    chk("R13", "writes after clear", 32'(n_wr), 32'd1);
    cmp_bytes("R13", 144, 0, 4);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    fresh();
    wr(3'd4, 32'd1);
    exp_rsz = 2'b01; exp_wsz = 2'b11; exp_attr = 3'b101;
    setup(16, 128, 32);
    wr(3'd0, ctl(1'b1, 1'b0, 2'b01, 1'b1, 2'b11, 2'b01, 3'b101));
    for (int i = 0; i < 200; i++) begin
      if (n_rd >= 5) break;
      @(negedge clk);
    end
    // reset write lands on a cycle whose read is also acknowledged
    wr(3'd0, ctl(1'b1, 1'b1, 2'b01, 1'b1, 2'b11, 2'b01, 3'b101));
    chk("R2", "mem_req after soft reset", 32'(mem_req), 32'd0);
    rd(3'd0, v); chk("R2", "enable after reset write", 32'(v[0]), 32'd0);
    repeat (10) @(negedge clk);
    chk("R2", "no write after reset", 32'(n_wr), 32'd0);
    fresh();
    setup(16, 160, 16);
    wr(3'd0, ctl(1'b1, 1'b0, 2'b01, 1'b1, 2'b11, 2'b01, 3'b101));
    wait_done();
    @(negedge clk);
    chk("R2", "reads after restart", 32'(n_rd), 32'd16);
    chk("R2", "reads before write after restart", 32'(rd_before_wr), 32'd16);
    cmp_bytes("R2", 160, 16, 16);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_byte_to_line();
    t_line_to_byte();
    t_fixed_src();
    t_fixed_dst(2'b00, 224);
    t_fixed_dst(2'b10, 240);
    t_zero_count();
    t_done_blocks();
    t_soft_reset();
    fin = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!fin) begin
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail + 1);
      $finish;
    end
  end

endmodule